// File: doc/BRIEF.md
# SDRAM Single-Bank Access Sequencer

This block runs one bank of a synchronous DRAM through whole access cycles. The user side presents a request with a direction, a row, a starting column, the number of words wanted for a read, and the complete write burst. The block then places a row activate, a column read or write and a precharge on the command pins. It spaces them by the programmed row-to-column delay, write-recovery delay and row cycle time. Read words come back on a strobed return path once the programmed CAS latency has passed.

A read can be shortened. When fewer words than the burst length are requested, the precharge is placed early enough to cut the burst. Only the words that are already in flight inside the device then arrive. Writes always send a full burst and hold the precharge back until the recovery delay has passed. One handshake stalls new work until the row cycle time since the last activate has elapsed and all read data has been returned.

Top module: `sdr_bank_seq`

## Requirements
- R1: After reset the command pins show no-op ({cs_n,ras_n,cas_n,we_n} = 0111), sd_dqm is 1, sd_dq_oe is 0, rd_valid is 0 and req_ready is 1.
- R2: A request accepted on a clock edge (req_valid and req_ready both high) puts an activate (0011) on the pins in the next cycle, with the row on sd_addr and the bank parameter on sd_ba. The read (0101) or write (0100) command follows exactly TRCD cycles after the activate.
- R3: Two activates are at least TRC cycles apart. req_ready is low in the cycle after an accept. Back-to-back writes give activates exactly TRC cycles apart.
- R4: A read command carries the column on sd_addr[COL_W-1:0] with all other address bits, including bit 10, low. The first returned word appears on rd_data with rd_valid exactly CL+1 cycles after the read command. Further words follow on consecutive cycles in column order.
- R5: For req_rd_len k with 1 <= k < BL, precharge (0010) comes exactly k cycles after the read command and exactly k words are returned. For req_rd_len of 0 or of BL or more, precharge comes BL cycles after the read command and BL words are returned.
- R6: A write command has sd_addr equal to the column, with bit 10 low. sd_dq_oe is high for exactly BL consecutive cycles starting with the write command cycle. Beat i drives req_wdata[i*DW +: DW].
- R7: Precharge after a write comes exactly BL-1+TRDL cycles after the write command, and sd_dq_oe is low in the precharge cycle.
- R8: During a precharge, sd_addr bit 10 is low, which selects a single bank, and sd_ba equals the bank parameter.
- R9: sd_dqm is low exactly in the write beat cycles and in the read window (from the read command cycle through the cycle before precharge), and it is high in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | AW | Row to open |
| req_col | input | COL_W | Starting column |
| req_rd_len | input | $clog2(BL+1) | Read words wanted; 0 or >= BL means full burst |
| req_wdata | input | BL*DW | Write burst, beat 0 in the low bits |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DW | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | AW | Row/column address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_o | output | DW | Write data to the pins |
| sd_dq_oe | output | 1 | Output enable for sd_dq_o |
| sd_dq_i | input | DW | Read data from the pins |

## Verification
The assertions assume that the timing parameters leave room for a whole cycle: TRC is at least TRCD+BL+TRDL, and the column width stays below address bit 10. With these values the precharge always lands before the next activate may fall due. They also assume the device returns read data only in the CL-delayed window and stops CL-1 cycles after a precharge. The bench's memory responder follows this exactly. It drives a junk value outside the window, so any word sampled at the wrong time shows up as a data mismatch. Stimulus changes only on falling edges and always waits for req_ready, so no request is offered while the block is still in a cycle.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RCD,
    ST_RD,
    ST_WR
  } seq_st_e;
endpackage

// File: rtl/sdr_rst_sync.sv
module sdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/sdr_wrdrv.sv
module sdr_wrdrv #(
  parameter int DW = 16,
  parameter int BL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic [BL*DW-1:0] cap_data,
  input  logic            go,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe
);
  localparam int CW = $clog2(BL + 1);

  logic [BL*DW-1:0] sh_q, sh_d;
  logic [CW-1:0]    left_q, left_d;
  logic             sh_en;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    sh_en  = 1'b0;
    if (cap) begin
      sh_d  = cap_data;
      sh_en = 1'b1;
    end else if (go) begin
      left_d = CW'(BL);
    end else if (left_q != '0) begin
      sh_d   = sh_q >> DW;
      sh_en  = 1'b1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      if (sh_en) sh_q <= sh_d;
      left_q <= left_d;
    end
  end

  assign dq_o  = sh_q[DW-1:0];
  assign dq_oe = (left_q != '0);

  // a new burst only starts on an idle driver
  p_go_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (left_q == '0));
  p_cap_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> !dq_oe);
endmodule

// File: rtl/sdr_rdcap.sv
module sdr_rdcap #(
  parameter int DW = 16,
  parameter int CL = 3,
  parameter int BL = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [$clog2(BL+1)-1:0]  words,
  input  logic [DW-1:0]            dq_i,
  output logic                     rd_valid,
  output logic [DW-1:0]            rd_data,
  output logic                     busy
);
  localparam int DLW = $clog2(CL + 1);
  localparam int NW  = $clog2(BL + 1);

  logic [DLW-1:0] dly_q, dly_d;
  logic [NW-1:0]  num_q, num_d;
  logic           cap;
  logic           rv_q;
  logic [DW-1:0]  rdat_q;

  assign cap = (dly_q == '0) && (num_q != '0);

  always_comb begin
    dly_d = dly_q;
    num_d = num_q;
    if (start) begin
      dly_d = DLW'(CL);
      num_d = words;
    end else begin
      if (dly_q != '0) dly_d = dly_q - 1'b1;
      if (cap)         num_d = num_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      num_q  <= '0;
      rv_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      dly_q <= dly_d;
      num_q <= num_d;
      rv_q  <= cap;
      if (cap) rdat_q <= dq_i;
    end
  end

  assign rd_valid = rv_q;
  assign rd_data  = rdat_q;
  assign busy     = (num_q != '0);

  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_start_words_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (words != '0) && (words <= NW'(BL)));
endmodule

// File: rtl/sdr_bank_seq.sv
module sdr_bank_seq
  import sdr_seq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 13,
  parameter int COL_W  = 9,
  parameter int BA_W   = 2,
  parameter int BANK   = 0,
  parameter int AP_BIT = 10,
  parameter int BL     = 4,
  parameter int CL     = 3,
  parameter int TRCD   = 2,
  parameter int TRC    = 8,
  parameter int TRDL   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_row,
  input  logic [COL_W-1:0]         req_col,
  input  logic [$clog2(BL+1)-1:0]  req_rd_len,
  input  logic [BL*DW-1:0]         req_wdata,
  output logic                     rd_valid,
  output logic [DW-1:0]            rd_data,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [BA_W-1:0]          sd_ba,
  output logic [AW-1:0]            sd_addr,
  output logic                     sd_dqm,
  output logic [DW-1:0]            sd_dq_o,
  output logic                     sd_dq_oe,
  input  logic [DW-1:0]            sd_dq_i
);
  localparam int LEN_W    = $clog2(BL + 1);
  localparam int WAIT_MAX = (BL + TRDL > TRCD) ? (BL + TRDL) : TRCD;
  localparam int CW       = $clog2(WAIT_MAX + 1);
  localparam int RCW      = $clog2(TRC + 1);
  localparam int SW       = $clog2(TRC + TRCD + 2);

  logic rst_s_n;

  sdr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  seq_st_e          st_q, st_d;
  sdr_cmd_e         cmd_q, cmd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RCW-1:0]   rc_q, rc_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             wr_q, wr_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] eff_len;
  logic [AW-1:0]    col_addr;
  logic             accept;
  logic             rd_go, wr_go;
  logic             rd_busy;

  assign req_ready = (st_q == ST_IDLE) && (rc_q == '0) && !rd_busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    eff_len = req_rd_len;
    if (req_rd_len == '0 || req_rd_len >= LEN_W'(BL)) eff_len = LEN_W'(BL);
  end

  always_comb begin
    col_addr              = '0;
    col_addr[COL_W-1:0]   = col_q;
    col_addr[AP_BIT]      = 1'b0;
  end

  // next-state process
  always_comb begin
    st_d   = st_q;
    cmd_d  = CMD_NOP;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    col_d  = col_q;
    wr_d   = wr_q;
    len_d  = len_q;
    rc_d   = (rc_q != '0) ? rc_q - 1'b1 : rc_q;
    rd_go  = 1'b0;
    wr_go  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cmd_d  = CMD_ACT;
          addr_d = req_row;
          rc_d   = RCW'(TRC - 1);
          cnt_d  = CW'(TRCD - 1);
          col_d  = req_col;
          wr_d   = req_write;
          len_d  = eff_len;
          st_d   = ST_RCD;
        end
      end
      ST_RCD: begin
        if (cnt_q == '0) begin
          addr_d = col_addr;
          if (wr_q) begin
            cmd_d = CMD_WR;
            cnt_d = CW'(BL + TRDL - 2);
            wr_go = 1'b1;
            st_d  = ST_WR;
          end else begin
            cmd_d = CMD_RD;
            cnt_d = CW'(len_q) - CW'(1);
            rd_go = 1'b1;
            st_d  = ST_RD;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RD, ST_WR: begin
        if (cnt_q == '0) begin
          cmd_d  = CMD_PRE;
          addr_d = '0;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      cnt_q  <= '0;
      rc_q   <= '0;
      addr_q <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      cnt_q  <= cnt_d;
      rc_q   <= rc_d;
      addr_q <= addr_d;
      if (accept) begin
        col_q <= col_d;
        wr_q  <= wr_d;
        len_q <= len_d;
      end
    end
  end

  sdr_wrdrv #(.DW(DW), .BL(BL)) u_wr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cap      (accept && req_write),
    .cap_data (req_wdata),
    .go       (wr_go),
    .dq_o     (sd_dq_o),
    .dq_oe    (sd_dq_oe)
  );

  sdr_rdcap #(.DW(DW), .CL(CL), .BL(BL)) u_rd (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start    (rd_go),
    .words    (len_q),
    .dq_i     (sd_dq_i),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .busy     (rd_busy)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba   = BA_W'(BANK);
  assign sd_addr = addr_q;
  assign sd_dqm  = !((st_q == ST_RD) || sd_dq_oe);

  // checker: cycles since the last activate on the pins, saturating
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                since_q <= '1;
    else if (cmd_q == CMD_ACT)   since_q <= SW'(1);
    else if (since_q != '1)      since_q <= since_q + 1'b1;
  end

  p_act_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |=> (cmd_q == CMD_ACT));
  p_rcd_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (since_q == SW'(TRCD)));
  p_trc_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_q == CMD_ACT) |-> (since_q >= SW'(TRC)));
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |=> !req_ready);
  p_rdl_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_q == CMD_PRE) |-> !sd_dq_oe);
  p_a10_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR || cmd_q == CMD_PRE) |-> !sd_addr[AP_BIT]);
  p_dqm_wr_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    sd_dq_oe |-> !sd_dqm);
endmodule

// File: tb/tb_sdr_bank_seq.sv
module tb_sdr_bank_seq;
  localparam int DW = 16, AW = 13, COL_W = 9, BA_W = 2, BANK = 1, AP_BIT = 10;
  localparam int BL = 4, CL = 3, TRCD = 2, TRC = 8, TRDL = 2;
  localparam int LEN_W = $clog2(BL + 1);

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [LEN_W-1:0] req_rd_len;
  logic [BL*DW-1:0] req_wdata;
  logic rd_valid;
  logic [DW-1:0] rd_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BA_W-1:0] sd_ba;
  logic [AW-1:0] sd_addr;
  logic sd_dqm, sd_dq_oe;
  logic [DW-1:0] sd_dq_o, sd_dq_i;

  sdr_bank_seq #(.DW(DW), .AW(AW), .COL_W(COL_W), .BA_W(BA_W), .BANK(BANK),
    .AP_BIT(AP_BIT), .BL(BL), .CL(CL), .TRCD(TRCD), .TRC(TRC), .TRDL(TRDL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .req_rd_len(req_rd_len), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errs = 0;
  int checks = 0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] r, input int c);
    logic [7:0] cl;
    cl = c[7:0];
    return {r[7:0] ^ 8'h5A, cl};
  endfunction

  logic [3:0] pc;
  assign pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // memory responder
  logic [AW-1:0] rsp_row = '0;
  int rsp_col = 0, rsp_t = 0, rsp_pre = 99;
  logic rsp_on = 1'b0;
  logic drive;
  always @(posedge clk) begin
    if (pc == 4'b0011) rsp_row <= sd_addr;
    if (pc == 4'b0101) begin
      rsp_on <= 1'b1; rsp_t <= 1; rsp_pre <= 99;
      rsp_col <= int'(sd_addr[COL_W-1:0]);
    end else if (rsp_on) begin
      rsp_t <= rsp_t + 1;
      if (pc == 4'b0010) rsp_pre <= rsp_t;
    end
  end
  assign drive   = rsp_on && rsp_t >= CL && (rsp_t - CL) < BL && rsp_t < rsp_pre + CL;
  assign sd_dq_i = drive ? pat(rsp_row, rsp_col + rsp_t - CL) : 16'hBAD0;

  // monitor / log
  int cyc = 0, act_cyc = 0, prev_act = 0, rw_cyc = 0, pre_cyc = 0;
  int first_rv = 0, last_rv = 0, rv_n = 0, wn = 0, last_w = 0, dqm_lo = 0;
  logic [AW-1:0] act_row, rw_addr, pre_addr;
  logic [BA_W-1:0] act_ba, pre_ba;
  logic [3:0] rw_cmd;
  logic pre_oe;
  logic [DW-1:0] rbuf [16];
  logic [DW-1:0] wbuf [16];
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (pc == 4'b0011) begin prev_act = act_cyc; act_cyc = cyc; act_row = sd_addr; act_ba = sd_ba; end
    if (pc == 4'b0101 || pc == 4'b0100) begin rw_cyc = cyc; rw_cmd = pc; rw_addr = sd_addr; end
    if (pc == 4'b0010) begin pre_cyc = cyc; pre_addr = sd_addr; pre_ba = sd_ba; pre_oe = sd_dq_oe; end
    if (rd_valid) begin
      if (rv_n == 0) first_rv = cyc;
      last_rv = cyc;
      if (rv_n < 16) rbuf[rv_n] = rd_data;
      rv_n = rv_n + 1;
    end
    if (sd_dq_oe && !sd_dqm) begin
      if (wn < 16) wbuf[wn] = sd_dq_o;
      wn = wn + 1; last_w = cyc;
    end
    if (!sd_dqm) dqm_lo = dqm_lo + 1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    rv_n = 0; wn = 0; dqm_lo = 0;
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] row, input logic [COL_W-1:0] col,
                       input int len, input logic [BL*DW-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_row = row; req_col = col;
    req_rd_len = LEN_W'(len); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cmd nop", pc, 4'b0111);
    chk("R1 dqm", sd_dqm, 1);
    chk("R1 dq_oe", sd_dq_oe, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_write(input logic [AW-1:0] row, input logic [COL_W-1:0] col,
                         input logic [BL*DW-1:0] wd);
    logic [AW-1:0] ea;
    ea = '0; ea[COL_W-1:0] = col;
    clear_log();
    issue(1'b1, row, col, 0, wd);
    repeat (TRC + 6) @(negedge clk);
    chk("R2 act row", act_row, row);
    chk("R2 act bank", act_ba, BANK);
    chk("R2 act to write", rw_cyc - act_cyc, TRCD);
    chk("R6 write cmd", rw_cmd, 4'b0100);
    chk("R6 write addr", rw_addr, ea);
    chk("R6 beat count", wn, BL);
    chk("R6 last beat", last_w - rw_cyc, BL - 1);
    for (int i = 0; i < BL; i++) chk("R6 beat data", wbuf[i], wd[i*DW +: DW]);
    chk("R7 write to precharge", pre_cyc - rw_cyc, BL - 1 + TRDL);
    chk("R7 oe at precharge", pre_oe, 0);
    chk("R8 precharge a10", pre_addr[AP_BIT], 0);
    chk("R8 precharge bank", pre_ba, BANK);
    chk("R9 dqm low write", dqm_lo, BL);
  endtask

  task automatic t_read(input logic [AW-1:0] row, input logic [COL_W-1:0] col, input int len);
    int k;
    logic [AW-1:0] ea;
    ea = '0; ea[COL_W-1:0] = col;
    k = (len == 0 || len >= BL) ? BL : len;
    clear_log();
    issue(1'b0, row, col, len, '0);
    repeat (TRC + CL + BL + 6) @(negedge clk);
    chk("R2 act row", act_row, row);
    chk("R2 act to read", rw_cyc - act_cyc, TRCD);
    chk("R4 read cmd", rw_cmd, 4'b0101);
    chk("R4 read addr", rw_addr, ea);
    chk("R4 first word latency", first_rv - rw_cyc, CL + 1);
    chk("R4 consecutive words", last_rv - first_rv, k - 1);
    chk("R5 read to precharge", pre_cyc - rw_cyc, k);
    chk("R5 word count", rv_n, k);
    for (int i = 0; i < k; i++) chk("R4 read data", rbuf[i], pat(row, int'(col) + i));
    chk("R8 precharge a10", pre_addr[AP_BIT], 0);
    chk("R9 dqm low read", dqm_lo, k);
  endtask

  task automatic t_b2b();
    issue(1'b1, 13'h0123, 9'h010, 0, 64'h1111_2222_3333_4444);
    chk("R3 ready low after accept", req_ready, 0);
    issue(1'b1, 13'h0456, 9'h020, 0, 64'h5555_6666_7777_8888);
    repeat (TRC + 6) @(negedge clk);
    chk("R3 write act gap", act_cyc - prev_act, TRC);
    issue(1'b0, 13'h0789, 9'h030, 0, '0);
    issue(1'b1, 13'h0abc, 9'h040, 0, 64'h9999_aaaa_bbbb_cccc);
    repeat (TRC + 6) @(negedge clk);
    checks++;
    if (act_cyc - prev_act < TRC) begin
      errs++;
      $display("FAIL R3 read act gap: actual=%0d expected>=%0d", act_cyc - prev_act, TRC);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_row = '0;
    req_col = '0; req_rd_len = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write(13'h1ABC, 9'h040, 64'hDEAD_BEEF_CAFE_F00D);
    t_read(13'h0F0F, 9'h080, 0);
    t_read(13'h0321, 9'h004, 1);
    t_read(13'h1111, 9'h008, 3);
    t_read(13'h0777, 9'h00C, 2);
    t_read(13'h0055, 9'h100, 6);
    t_write(13'h0002, 9'h1F0, 64'h0102_0304_0506_0708);
    t_b2b();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule